// File: doc/BRIEF.md
# Multiple-Word Store Sequencer

This block carries out a store-multiple-word operation over several cycles. It takes one command holding a start register number, a base register number with that register's value, and a signed 16-bit displacement. It then walks from the start register up to the highest register, register 31, one register per cycle. For each register it fetches the value through an external register-file read port. It then issues a word-wide store request that carries the low 32 bits of that register.

The first store address is the displacement, sign-extended, added to the base value. When the base register number is 0, the base counts as zero and the supplied value is ignored. Each later store goes to the next word, 4 bytes higher. The base register is never written back, and no other architectural state changes.

The store port uses a valid/ready handshake. The sequencer holds its request for as long as ready is low. While it works it refuses new commands. One cycle after the final store is accepted it raises a single-cycle completion pulse. The register read address runs one cycle ahead of the store request, so an unstalled run issues one store every cycle.

Top module: `smw_store_seq`

## Requirements
- R1: The first store address equals `cmd_base_val_i` plus `cmd_disp_i` sign-extended to 64 bits. When `cmd_base_reg_i` is 0, the base is taken as zero whatever `cmd_base_val_i` holds.
- R2: Each store request's data equals bits [31:0] of the register being stored. The register file returns, in the cycle after `rf_raddr_o` names a register, that register's value on `rf_rdata_i`.
- R3: After each accepted store, the next request is for register index plus 1, at address plus 4, wrapping modulo 2^64.
- R4: A command with start register N produces exactly 32−N accepted stores, for registers N through 31. A start of 31 gives one store, and a start of 0 gives 32 stores. `st_valid_o` is low after the final store is accepted.
- R5: While `st_valid_o` is high and `st_ready_i` is low, the request stays valid and its address and data do not change.
- R6: The first request is valid in the cycle after the command is taken. While stores remain, `st_valid_o` stays high in every cycle, so with ready held high one store is accepted per cycle.
- R7: `cmd_ready_o` is high only when idle. A command is taken when `cmd_valid_i` and `cmd_ready_o` are both high. A `cmd_valid_i` raised while busy has no effect on the running sequence.
- R8: `done_o` is high for exactly one cycle. That cycle directly follows the cycle in which the final store was accepted.
- R9: A synchronous reset, `rst_i` high, returns the block to idle. After reset there is no pending request, `done_o` is low and `cmd_ready_o` is high, even if reset arrives in the middle of a sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| cmd_valid_i | input | 1 | Command offered |
| cmd_ready_o | output | 1 | Sequencer idle, command can be taken |
| cmd_first_reg_i | input | 5 | First register to store |
| cmd_base_reg_i | input | 5 | Base register number (0 means zero base) |
| cmd_base_val_i | input | 64 | Value of the base register |
| cmd_disp_i | input | 16 | Signed displacement |
| rf_raddr_o | output | 5 | Register-file read address |
| rf_rdata_i | input | 64 | Register-file read data, one cycle after the address |
| st_valid_o | output | 1 | Store request valid |
| st_ready_i | input | 1 | Store request accepted when high with valid |
| st_addr_o | output | 64 | Store byte address |
| st_data_o | output | 32 | Store word data |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
Directed commands cover the boundary starts and the address corners:
- Start 31 and start 0 tell a one-store run from a full 32-store run.
- A zero base register with a non-zero value separates the zero-base rule from a plain add.
- Negative and maximum displacements, and a base just below 2^64, expose sign-extension and wrap mistakes.

Random commands are then mixed with random ready stalls at several rates. Stalls show whether address, data and read address hold together, or drift apart by a cycle. Commands offered mid-run and a reset mid-run check that a busy sequence is neither disturbed nor left with a stale request.

// File: rtl/smw_pkg.sv
package smw_pkg;
   typedef enum logic [0:0] {
      SMW_IDLE = 1'b0,
      SMW_RUN  = 1'b1
   } smw_state_e;

   localparam int unsigned SMW_BYTE_W = 8;
endpackage

// File: rtl/smw_addr_gen.sv
module smw_addr_gen #(
   parameter int unsigned XLEN      = 64,
   parameter int unsigned DISP_W    = 16,
   parameter int unsigned REG_AW    = 5,
   parameter int unsigned STEP      = 4,
   parameter bit          ZERO_R0   = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              load_i,
   input  logic              step_i,
   input  logic [REG_AW-1:0] base_reg_i,
   input  logic [XLEN-1:0]   base_val_i,
   input  logic [DISP_W-1:0] disp_i,
   output logic [XLEN-1:0]   addr_o
);
   localparam int unsigned EXT_W = XLEN - DISP_W;

   logic [XLEN-1:0] base_eff;
   logic [XLEN-1:0] disp_ext;
   logic [XLEN-1:0] start_ea;
   logic [XLEN-1:0] addr_q;

   generate
      if (DISP_W >= XLEN) begin : g_bad_disp
         $error("smw_addr_gen: DISP_W must be narrower than XLEN");
      end
      if (ZERO_R0) begin : g_zero_base
         assign base_eff = (base_reg_i == '0) ? '0 : base_val_i;
      end else begin : g_plain_base
         assign base_eff = base_val_i;
      end
   endgenerate

   assign disp_ext = {{EXT_W{disp_i[DISP_W-1]}}, disp_i};
   assign start_ea = base_eff + disp_ext;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         addr_q <= '0;
      end else if (load_i) begin
         addr_q <= start_ea;
      end else if (step_i) begin
         addr_q <= addr_q + XLEN'(STEP);
      end
   end

   assign addr_o = addr_q;

   p_addr_hold_r5: assert property (@(posedge clk_i) disable iff (rst_i)
      (!load_i && !step_i) |=> $stable(addr_o));
endmodule

// File: rtl/smw_reg_walker.sv
module smw_reg_walker #(
   parameter int unsigned REG_AW   = 5,
   parameter int unsigned LAST_REG = 31
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              load_i,
   input  logic              step_i,
   input  logic [REG_AW-1:0] first_i,
   output logic [REG_AW-1:0] idx_o,
   output logic [REG_AW-1:0] raddr_o,
   output logic              last_o
);
   logic [REG_AW-1:0] idx_q;
   logic [REG_AW-1:0] idx_inc;

   generate
      if (LAST_REG >= (1 << REG_AW)) begin : g_bad_last
         $error("smw_reg_walker: LAST_REG does not fit in REG_AW bits");
      end
   endgenerate

   assign idx_inc = idx_q + REG_AW'(1);
   assign last_o  = (idx_q == REG_AW'(LAST_REG));

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         idx_q <= '0;
      end else if (load_i) begin
         idx_q <= first_i;
      end else if (step_i && !last_o) begin
         idx_q <= idx_inc;
      end
   end

   always_comb begin
      if (load_i) begin
         raddr_o = first_i;
      end else if (step_i && !last_o) begin
         raddr_o = idx_inc;
      end else begin
         raddr_o = idx_q;
      end
   end

   assign idx_o = idx_q;

   p_idx_advance_r3: assert property (@(posedge clk_i) disable iff (rst_i)
      (step_i && !last_o && !load_i) |=> (idx_o == $past(idx_o) + REG_AW'(1)));
   p_idx_hold_r5: assert property (@(posedge clk_i) disable iff (rst_i)
      (!step_i && !load_i) |=> $stable(idx_o));
endmodule

// File: rtl/smw_ctrl.sv
module smw_ctrl
   import smw_pkg::*;
(
   input  logic clk_i,
   input  logic rst_i,
   input  logic cmd_valid_i,
   input  logic st_ready_i,
   input  logic last_i,
   output logic cmd_ready_o,
   output logic load_o,
   output logic step_o,
   output logic st_valid_o,
   output logic done_o
);
   smw_state_e state_q;
   logic       done_q;
   logic       accept;

   assign cmd_ready_o = (state_q == SMW_IDLE);
   assign load_o      = cmd_valid_i && cmd_ready_o;
   assign st_valid_o  = (state_q == SMW_RUN);
   assign accept      = st_valid_o && st_ready_i;
   assign step_o      = accept;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         state_q <= SMW_IDLE;
         done_q  <= 1'b0;
      end else begin
         done_q <= accept && last_i;
         case (state_q)
            SMW_IDLE: if (load_o) state_q <= SMW_RUN;
            SMW_RUN:  if (accept && last_i) state_q <= SMW_IDLE;
            default:  state_q <= SMW_IDLE;
         endcase
      end
   end

   assign done_o = done_q;

   p_stall_keeps_valid_r5: assert property (@(posedge clk_i) disable iff (rst_i)
      (st_valid_o && !st_ready_i) |=> st_valid_o);
   p_done_single_r8: assert property (@(posedge clk_i) disable iff (rst_i)
      done_o |=> !done_o);
   p_done_after_last_r8: assert property (@(posedge clk_i) disable iff (rst_i)
      (st_valid_o && st_ready_i && last_i) |=> (done_o && !st_valid_o));
   p_run_continues_r6: assert property (@(posedge clk_i) disable iff (rst_i)
      (st_valid_o && !last_i) |=> st_valid_o);
endmodule

// File: rtl/smw_store_seq.sv
module smw_store_seq #(
   parameter int unsigned XLEN    = 64,
   parameter int unsigned WORD_W  = 32,
   parameter int unsigned DISP_W  = 16,
   parameter int unsigned REG_AW  = 5,
   parameter bit          ZERO_R0 = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              cmd_valid_i,
   output logic              cmd_ready_o,
   input  logic [REG_AW-1:0] cmd_first_reg_i,
   input  logic [REG_AW-1:0] cmd_base_reg_i,
   input  logic [XLEN-1:0]   cmd_base_val_i,
   input  logic [DISP_W-1:0] cmd_disp_i,
   output logic [REG_AW-1:0] rf_raddr_o,
   input  logic [XLEN-1:0]   rf_rdata_i,
   output logic              st_valid_o,
   input  logic              st_ready_i,
   output logic [XLEN-1:0]   st_addr_o,
   output logic [WORD_W-1:0] st_data_o,
   output logic              done_o
);
   localparam int unsigned NUM_REGS = 1 << REG_AW;
   localparam int unsigned LAST_REG = NUM_REGS - 1;
   localparam int unsigned STEP     = WORD_W / smw_pkg::SMW_BYTE_W;

   logic              load;
   logic              step;
   logic              last;
   logic [REG_AW-1:0] idx;

   generate
      if (WORD_W > XLEN) begin : g_bad_word
         $error("smw_store_seq: WORD_W exceeds XLEN");
      end
      if ((WORD_W % smw_pkg::SMW_BYTE_W) != 0) begin : g_bad_bytes
         $error("smw_store_seq: WORD_W must be whole bytes");
      end
   endgenerate

   smw_ctrl i_ctrl (
      .clk_i       (clk_i),
      .rst_i       (rst_i),
      .cmd_valid_i (cmd_valid_i),
      .st_ready_i  (st_ready_i),
      .last_i      (last),
      .cmd_ready_o (cmd_ready_o),
      .load_o      (load),
      .step_o      (step),
      .st_valid_o  (st_valid_o),
      .done_o      (done_o)
   );

   smw_reg_walker #(
      .REG_AW   (REG_AW),
      .LAST_REG (LAST_REG)
   ) i_walker (
      .clk_i   (clk_i),
      .rst_i   (rst_i),
      .load_i  (load),
      .step_i  (step),
      .first_i (cmd_first_reg_i),
      .idx_o   (idx),
      .raddr_o (rf_raddr_o),
      .last_o  (last)
   );

   smw_addr_gen #(
      .XLEN    (XLEN),
      .DISP_W  (DISP_W),
      .REG_AW  (REG_AW),
      .STEP    (STEP),
      .ZERO_R0 (ZERO_R0)
   ) i_addr (
      .clk_i      (clk_i),
      .rst_i      (rst_i),
      .load_i     (load),
      .step_i     (step),
      .base_reg_i (cmd_base_reg_i),
      .base_val_i (cmd_base_val_i),
      .disp_i     (cmd_disp_i),
      .addr_o     (st_addr_o)
   );

   assign st_data_o = rf_rdata_i[WORD_W-1:0];

   p_stall_hold_r5: assert property (@(posedge clk_i) disable iff (rst_i)
      (st_valid_o && !st_ready_i) |=> (st_valid_o && $stable(st_addr_o) && $stable(idx)));
   p_addr_stride_r3: assert property (@(posedge clk_i) disable iff (rst_i)
      (st_valid_o && st_ready_i && !last) |=> (st_addr_o == $past(st_addr_o) + XLEN'(STEP)));
   p_busy_blocks_cmd_r7: assert property (@(posedge clk_i) disable iff (rst_i)
      (st_valid_o && cmd_valid_i) |=> $stable(idx) || (idx == $past(idx) + REG_AW'(1)));
   p_raddr_tracks_r2: assert property (@(posedge clk_i) disable iff (rst_i)
      (st_valid_o && !st_ready_i) |-> (rf_raddr_o == idx));
endmodule

// File: tb/test_smw_store_seq.sv
module test_smw_store_seq;
   localparam int CLK_PERIOD = 10;

   logic        clk_i = 1'b0;
   logic        rst_i;
   logic        cmd_valid_i;
   logic        cmd_ready_o;
   logic [4:0]  cmd_first_reg_i;
   logic [4:0]  cmd_base_reg_i;
   logic [63:0] cmd_base_val_i;
   logic [15:0] cmd_disp_i;
   logic [4:0]  rf_raddr_o;
   logic [63:0] rf_rdata_i;
   logic        st_valid_o;
   logic        st_ready_i;
   logic [63:0] st_addr_o;
   logic [31:0] st_data_o;
   logic        done_o;

   logic [63:0] rf [32];
   int n_checks = 0;
   int n_fail   = 0;

   always #(CLK_PERIOD/2) clk_i = ~clk_i;

   always @(posedge clk_i) rf_rdata_i <= rf[rf_raddr_o];

   smw_store_seq i_smw_store_seq (
      .clk_i           (clk_i),
      .rst_i           (rst_i),
      .cmd_valid_i     (cmd_valid_i),
      .cmd_ready_o     (cmd_ready_o),
      .cmd_first_reg_i (cmd_first_reg_i),
      .cmd_base_reg_i  (cmd_base_reg_i),
      .cmd_base_val_i  (cmd_base_val_i),
      .cmd_disp_i      (cmd_disp_i),
      .rf_raddr_o      (rf_raddr_o),
      .rf_rdata_i      (rf_rdata_i),
      .st_valid_o      (st_valid_o),
      .st_ready_i      (st_ready_i),
      .st_addr_o       (st_addr_o),
      .st_data_o       (st_data_o),
      .done_o          (done_o)
   );

   function automatic logic [63:0] exp_start(input logic [4:0] breg,
                                              input logic [63:0] bval,
                                              input logic [15:0] disp);
      logic [63:0] b;
      b = (breg == 5'd0) ? 64'd0 : bval;
      return b + {{48{disp[15]}}, disp};
   endfunction

   task automatic chk(input bit ok, input string req, input logic [63:0] act,
                      input logic [63:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
   endtask

   task automatic run_cmd(input logic [4:0] first, input logic [4:0] breg,
                          input logic [63:0] bval, input logic [15:0] disp,
                          input int stall_pct, input bit inject);
      logic [63:0] ea;
      int r;
      int it;
      bit rdy;
      ea = exp_start(breg, bval, disp);
      chk(cmd_ready_o == 1'b1, "R7 idle ready", 64'(cmd_ready_o), 64'd1);
      cmd_valid_i     = 1'b1;
      cmd_first_reg_i = first;
      cmd_base_reg_i  = breg;
      cmd_base_val_i  = bval;
      cmd_disp_i      = disp;
      @(negedge clk_i);
      cmd_valid_i = 1'b0;
      r  = first;
      it = 0;
      while (r < 32) begin
         chk(st_valid_o == 1'b1, "R6 request valid", 64'(st_valid_o), 64'd1);
         chk(cmd_ready_o == 1'b0, "R7 busy refuses", 64'(cmd_ready_o), 64'd0);
         chk(st_addr_o == ea, (r == first) ? "R1 start address" : "R3 step address",
             st_addr_o, ea);
         chk(st_data_o == rf[r][31:0], "R2 store data", 64'(st_data_o), 64'(rf[r][31:0]));
         rdy = ($urandom % 100) >= stall_pct;
         st_ready_i = rdy;
         if (inject && it == 1) begin
            cmd_valid_i     = 1'b1;
            cmd_first_reg_i = 5'($urandom);
            cmd_base_reg_i  = 5'($urandom);
            cmd_base_val_i  = {$urandom, $urandom};
            cmd_disp_i      = 16'($urandom);
         end
         @(negedge clk_i);
         cmd_valid_i = 1'b0;
         if (rdy) begin
            r++;
            ea = ea + 64'd4;
         end
         it++;
      end
      st_ready_i = 1'b0;
      chk(done_o == 1'b1, "R8 done pulse", 64'(done_o), 64'd1);
      chk(st_valid_o == 1'b0, "R4 no extra store", 64'(st_valid_o), 64'd0);
      @(negedge clk_i);
      chk(done_o == 1'b0, "R8 done one cycle", 64'(done_o), 64'd0);
      chk(cmd_ready_o == 1'b1, "R7 ready again", 64'(cmd_ready_o), 64'd1);
   endtask

   initial begin
      repeat (150000) @(posedge clk_i);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
   end

   initial begin
      void'($urandom(32'd1357));
      for (int i = 0; i < 32; i++) rf[i] = {$urandom, $urandom};
      rst_i = 1'b1;
      cmd_valid_i = 1'b0;
      cmd_first_reg_i = '0;
      cmd_base_reg_i = '0;
      cmd_base_val_i = '0;
      cmd_disp_i = '0;
      st_ready_i = 1'b0;
      repeat (3) @(negedge clk_i);
      rst_i = 1'b0;
      // R9 reset state
      chk(st_valid_o == 1'b0, "R9 reset valid", 64'(st_valid_o), 64'd0);
      chk(done_o == 1'b0, "R9 reset done", 64'(done_o), 64'd0);
      chk(cmd_ready_o == 1'b1, "R9 reset ready", 64'(cmd_ready_o), 64'd1);

      // R4 one store, R1 zero base with non-zero value
      run_cmd(5'd31, 5'd0, 64'hDEAD_BEEF_0000_1000, 16'h0040, 0, 1'b0);
      // R4 full 32 stores, negative displacement
      run_cmd(5'd0, 5'd7, 64'h0000_0000_0001_0000, 16'hFFF0, 0, 1'b0);
      // R1 max positive displacement, R3 wrap near 2^64
      run_cmd(5'd28, 5'd3, 64'hFFFF_FFFF_FFFF_FFF8, 16'h7FFF, 30, 1'b0);
      run_cmd(5'd29, 5'd12, 64'hFFFF_FFFF_FFFF_FFF4, 16'h0000, 0, 1'b1);
      // R5 heavy stalls, R7 command offered while busy
      run_cmd(5'd20, 5'd1, 64'h0000_1234_5678_0000, 16'h8000, 70, 1'b1);

      for (int n = 0; n < 24; n++) begin
         for (int i = 0; i < 32; i++) rf[i] = {$urandom, $urandom};
         run_cmd(5'($urandom), 5'($urandom), {$urandom, $urandom}, 16'($urandom),
                 int'($urandom % 60), 1'($urandom));
      end

      // R9 reset in the middle of a sequence
      cmd_valid_i = 1'b1;
      cmd_first_reg_i = 5'd10;
      cmd_base_reg_i = 5'd2;
      cmd_base_val_i = 64'h100;
      cmd_disp_i = 16'h0;
      st_ready_i = 1'b1;
      @(negedge clk_i);
      cmd_valid_i = 1'b0;
      repeat (3) @(negedge clk_i);
      rst_i = 1'b1;
      @(negedge clk_i);
      rst_i = 1'b0;
      st_ready_i = 1'b0;
      chk(st_valid_o == 1'b0, "R9 mid reset valid", 64'(st_valid_o), 64'd0);
      chk(done_o == 1'b0, "R9 mid reset done", 64'(done_o), 64'd0);
      chk(cmd_ready_o == 1'b1, "R9 mid reset ready", 64'(cmd_ready_o), 64'd1);
      @(negedge clk_i);
      chk(st_valid_o == 1'b0, "R9 stays idle", 64'(st_valid_o), 64'd0);
      run_cmd(5'd30, 5'd5, 64'h2000, 16'h0004, 20, 1'b0);

      summary();
      $finish;
   end
endmodule